// File: doc/BRIEF.md
# Configurable SPI Host Shift Engine

This block serializes one word at a time onto a synchronous serial link as the clocking side. A word offered on a ready/valid input is captured and shifted out on `mosi` while `sclk` is generated from the module clock by a programmable divider. The data returned on `miso` is gathered into a word that is right-aligned and presented on a one-cycle valid output. A `busy` flag covers the whole word, up to the end of the final bit period.

A control word and a divider value set the serial format. Both are captured on a configuration strobe, and the strobe takes effect only while the engine is disabled and idle. The control word selects clock polarity, the idle data level, sampling phase, bit order, internal loopback, word length (2 to 32 bits), and switches that turn the transmitter and the receiver off independently.

The state machine has three states. `ST_IDLE` holds `sclk` at its rest level and offers `tx_ready`. `ST_FIRST_HALF` is the first half of a bit period, and `ST_SECOND_HALF` is the second half. The transitions are as follows:
- IDLE→FIRST on a handshake (start).
- FIRST→SECOND when the half-period timer expires (sample).
- SECOND→FIRST on expiry when bits remain (advance).
- SECOND→IDLE on expiry after the last bit (finish).

Top module: `spi_shift_host`

## Requirements
- R1: Control word layout: bit0 = clock polarity, bit1 = idle data level, bit2 = phase select, bit3 = MSB-first, bit4 = loopback, bit5 = transmitter off, bit6 = receiver off, bits 11:7 = word length minus one. The divider and the control word are captured on `cfg_we` only when `en` is low and `busy` is low; otherwise the strobe is ignored. The reset values are divider 0, polarity 0, idle level 0, phase select 1, MSB-first 1, loopback 0, both off bits 0, and an 8-bit word.
- R2: Each half of every bit period lasts divider+1 clocks, so one bit takes 2*(divider+1) clocks and a word of N bits takes N*2*(divider+1) clocks.
- R3: While no word is in progress, `sclk` rests at the polarity bit.
- R4: Phase select 1: the bit is valid before the first edge, it is sampled on the leading `sclk` edge, and it changes after the trailing edge. Phase select 0: the bit changes on the leading edge and is sampled on the trailing edge.
- R5: MSB-first = 1 shifts bit N-1 first. MSB-first = 0 shifts bit 0 first. Received bits are placed with the same order.
- R6: The word length is the length field plus one. `rx_data` holds the received bits in positions N-1..0, and every higher bit is zero.
- R7: With loopback set, the receiver takes the engine's own `mosi` and ignores `miso`.
- R8: `mosi` carries the idle level whenever no word is in progress, and for the whole word when the transmitter is off.
- R9: With the receiver off, a finished word raises no `rx_valid` and `rx_data` keeps its previous value.
- R10: `tx_ready` is high only when `en` is high and no word is in progress. `busy` rises on the cycle after the handshake and stays high until the last bit period has ended.
- R11: `rx_valid` is a one-cycle pulse in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; configuration locked while high |
| cfg_we | input | 1 | Configuration capture strobe |
| cfg_div | input | DIV_W | Half-period divider value |
| cfg_ctrl | input | 7+log2(DATA_W) | Control word (layout in R1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine accepts a word |
| tx_data | input | DATA_W | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | DATA_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in progress |

## Verification
The bench builds the engine with its defaults: 32-bit data and a 16-bit divider. This keeps the full 32-bit word length and the top bit index reachable, and so exposes the length-field edge at 31 as well as the 2-bit minimum. Divider values 0 to 2 keep the runs short while still separating the half-period count from the bit count in the busy-duration checks. A bench-side target model samples `mosi` and drives `miso` on the edges that the phase and polarity bits call for, so bit order and edge placement are checked on the wire itself.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST_HALF,
        ST_SECOND_HALF
    } shift_state_t;

    // control word field positions
    localparam int CTL_CPOL  = 0;
    localparam int CTL_IDLE  = 1;
    localparam int CTL_PH    = 2;
    localparam int CTL_MSB   = 3;
    localparam int CTL_LOOP  = 4;
    localparam int CTL_TXOFF = 5;
    localparam int CTL_RXOFF = 6;
    localparam int CTL_LEN   = 7;
    localparam int CTL_FLAGS = 7;

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
    parameter int DIV_W  = 16,
    parameter int CTRL_W = 12,
    parameter logic [CTRL_W-1:0] RST_CTRL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              en,
    input  logic              busy,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    output logic [DIV_W-1:0]  div_q,
    output logic [CTRL_W-1:0] ctrl_q
);

    logic accept;

    // settings may only move while the engine is parked
    assign accept = cfg_we && !en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            ctrl_q <= RST_CTRL;
        end else if (accept) begin
            div_q  <= cfg_div;
            ctrl_q <= cfg_ctrl;
        end
    end

endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_done
);

    logic [DIV_W-1:0] cnt_q;

    assign half_done = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              half_done,
    input  logic              miso,
    input  logic              cpol,
    input  logic              idle_lvl,
    input  logic              ph,
    input  logic              msb_first,
    input  logic              loop_en,
    input  logic              tx_off,
    input  logic              rx_off,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              tx_ready,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    shift_state_t state_q, state_d;

    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  pos;
    logic [DATA_W-1:0] tx_word_q;
    logic [DATA_W-1:0] rx_word_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              rx_valid_q;
    logic              start;
    logic              last_bit;
    logic              rx_bit;

    assign pos      = msb_first ? (len_m1 - idx_q) : idx_q;
    assign start    = (state_q == ST_IDLE) && en && tx_valid;
    assign last_bit = (idx_q == len_m1);
    assign rx_bit   = loop_en ? mosi : miso;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start)     state_d = ST_FIRST_HALF;
            ST_FIRST_HALF:  if (half_done) state_d = ST_SECOND_HALF;
            ST_SECOND_HALF: if (half_done) state_d = last_bit ? ST_IDLE : ST_FIRST_HALF;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        tx_ready = (state_q == ST_IDLE) && en;
        mosi     = (busy && !tx_off) ? tx_word_q[pos] : idle_lvl;
        sclk     = busy ? (cpol ^ !ph ^ (state_q == ST_SECOND_HALF)) : cpol;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            tx_word_q  <= '0;
            rx_word_q  <= '0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tx_word_q <= tx_data;
                        rx_word_q <= '0;
                        idx_q     <= '0;
                    end
                end
                ST_FIRST_HALF: begin
                    if (half_done) begin
                        rx_word_q[pos] <= rx_bit;
                    end
                end
                ST_SECOND_HALF: begin
                    if (half_done) begin
                        if (last_bit) begin
                            rx_valid_q <= !rx_off;
                            if (!rx_off) begin
                                rx_data_q <= rx_word_q;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;

endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
    import spi_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int CTRL_W = CTL_FLAGS + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    localparam logic [CTRL_W-1:0] RST_CTRL =
        {LEN_W'(7), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    logic [DIV_W-1:0]  div_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              half_done;

    spi_cfg_regs #(
        .DIV_W   (DIV_W),
        .CTRL_W  (CTRL_W),
        .RST_CTRL(RST_CTRL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .en      (en),
        .busy    (busy),
        .cfg_div (cfg_div),
        .cfg_ctrl(cfg_ctrl),
        .div_q   (div_q),
        .ctrl_q  (ctrl_q)
    );

    spi_half_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div_q),
        .half_done(half_done)
    );

    spi_shift_fsm #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .half_done(half_done),
        .miso     (miso),
        .cpol     (ctrl_q[CTL_CPOL]),
        .idle_lvl (ctrl_q[CTL_IDLE]),
        .ph       (ctrl_q[CTL_PH]),
        .msb_first(ctrl_q[CTL_MSB]),
        .loop_en  (ctrl_q[CTL_LOOP]),
        .tx_off   (ctrl_q[CTL_TXOFF]),
        .rx_off   (ctrl_q[CTL_RXOFF]),
        .len_m1   (ctrl_q[CTL_LEN +: LEN_W]),
        .tx_ready (tx_ready),
        .busy     (busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/spi_shift_host_chk.sv
module spi_shift_host_chk #(
    parameter int DIV_W  = 16,
    parameter int CTRL_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              busy,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              sclk,
    input logic              mosi,
    input logic [DIV_W-1:0]  div_q,
    input logic [CTRL_W-1:0] ctrl_q
);

    // R1: settings frozen while enabled or mid-word
    a_r1_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (en || busy) |=> ($stable(ctrl_q) && $stable(div_q)));

    // R3: clock rests at polarity level between words
    a_r3_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ctrl_q[0]));

    // R8: transmitter off drives idle level
    a_r8_txoff_mosi: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q[5]) |-> (mosi == ctrl_q[1]));

    // R9: receiver off gives no word pulse
    a_r9_rxoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[6] |-> !rx_valid);

    // R10: ready only when enabled and idle
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (en && !busy));

    // R11: single-cycle pulse right after busy falls
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r11_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!busy && $past(busy)));

endmodule

bind spi_shift_host spi_shift_host_chk #(
    .DIV_W (DIV_W),
    .CTRL_W(CTRL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .busy    (busy),
    .tx_ready(tx_ready),
    .rx_valid(rx_valid),
    .sclk    (sclk),
    .mosi    (mosi),
    .div_q   (div_q),
    .ctrl_q  (ctrl_q)
);

// File: tb/sim_spi_shift_host.sv
module sim_spi_shift_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [11:0] cfg_ctrl = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] tx_data = '0;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model of the active configuration
    bit m_cpol = 0, m_idle = 0, m_ph = 1, m_msb = 1, m_loop = 0, m_txoff = 0, m_rxoff = 0;
    int m_len = 8;
    int m_div = 0;

    logic [31:0] exp_mosi_q[$];
    logic [31:0] exp_rx_q[$];
    logic [31:0] slave_w = '0;
    logic [31:0] cap = '0;
    int k = 0;

    always #10 clk = ~clk;

    spi_shift_host u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_ctrl(cfg_ctrl), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int posf(input int i);
        return m_msb ? (m_len - 1 - i) : i;
    endfunction

    function automatic logic [31:0] maskf();
        return (m_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_len) - 32'd1);
    endfunction

    function automatic logic [11:0] mk(input bit cpol, input bit idl, input bit ph,
        input bit msb, input bit lp, input bit txo, input bit rxo, input int len);
        logic [4:0] l;
        l = 5'(len - 1);
        return {l, rxo, txo, lp, msb, ph, idl, cpol};
    endfunction

    // target model: samples mosi and drives miso on the phase-selected edges (R4, R5)
    initial begin
        forever begin
            @(sclk);
            #1;
            if (busy === 1'b1 && (m_ph ? (sclk != m_cpol) : (sclk == m_cpol))) begin
                cap[posf(k)] = mosi;
                k++;
                if (k < m_len) begin
                    miso = slave_w[posf(k)];
                end else begin
                    if (exp_mosi_q.size() == 0) begin
                        check(0, "R4 unexpected word on wire", cap, 32'h0);
                    end else begin
                        logic [31:0] e;
                        e = exp_mosi_q.pop_front();
                        check(cap == e, "R4/R5 mosi wire word", cap, e);
                    end
                    k = 0;
                    cap = '0;
                end
            end
        end
    end

    // received word monitor (R6, R7, R11)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid === 1'b1) begin
                if (exp_rx_q.size() == 0) begin
                    check(0, "R9 unexpected rx_valid", rx_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rx_q.pop_front();
                    check(rx_data == e, "R6/R7 rx_data", rx_data, e);
                end
            end
        end
    end

    task automatic configure(input int div, input logic [11:0] ctrl);
        bit applies;
        @(negedge clk);
        applies = !en && !busy;
        cfg_div = 16'(div);
        cfg_ctrl = ctrl;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (applies) begin
            m_div = div;
            m_cpol = ctrl[0]; m_idle = ctrl[1]; m_ph = ctrl[2]; m_msb = ctrl[3];
            m_loop = ctrl[4]; m_txoff = ctrl[5]; m_rxoff = ctrl[6];
            m_len = int'(ctrl[11:7]) + 1;
        end
    endtask

    task automatic send(input logic [31:0] w, input logic [31:0] s);
        logic [31:0] em;
        int n;
        int exp_n;
        em = m_txoff ? (m_idle ? maskf() : 32'h0) : (w & maskf());
        exp_mosi_q.push_back(em);
        if (!m_rxoff) exp_rx_q.push_back(m_loop ? em : (s & maskf()));
        slave_w = s;
        k = 0;
        cap = '0;
        miso = s[posf(0)];
        @(negedge clk);
        tx_data = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        exp_n = m_len * 2 * (m_div + 1);
        check(n == exp_n, "R2/R10 busy cycles", 32'(n), 32'(exp_n));
        check(sclk == m_cpol, "R3 sclk rest level", 32'(sclk), 32'(m_cpol));
        check(mosi == m_idle, "R8 mosi idle level", 32'(mosi), 32'(m_idle));
        @(negedge clk);
        @(negedge clk);
        check(exp_mosi_q.size() == 0, "R4 wire word seen", 32'(exp_mosi_q.size()), 32'h0);
        check(exp_rx_q.size() == 0, "R11 rx word seen", 32'(exp_rx_q.size()), 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(sclk == 1'b0, "R3 reset sclk", 32'(sclk), 32'h0);
        check(mosi == 1'b0, "R8 reset mosi", 32'(mosi), 32'h0);
        check(busy == 1'b0, "R10 reset busy", 32'(busy), 32'h0);
        check(rx_valid == 1'b0, "R11 reset rx_valid", 32'(rx_valid), 32'h0);
        check(rx_data == 32'h0, "R6 reset rx_data", rx_data, 32'h0);
        check(tx_ready == 1'b0, "R10 ready needs enable", 32'(tx_ready), 32'h0);

        en = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R10 ready when idle", 32'(tx_ready), 32'h1);

        // R1 reset configuration: 8-bit, MSB first, leading-edge sample, divider 0
        send(32'h0000_00A5, 32'h0000_003C);

        // R4 trailing-edge sampling, polarity high, idle level high, divider 2
        en = 1'b0;
        configure(2, mk(1, 1, 0, 1, 0, 0, 0, 8));
        en = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R3 polarity rest high", 32'(sclk), 32'h1);
        send(32'h0000_0096, 32'h0000_00E1);

        // R5 LSB first, 16-bit word, divider 1
        en = 1'b0;
        configure(1, mk(0, 0, 1, 0, 0, 0, 0, 16));
        en = 1'b1;
        send(32'h0000_1234, 32'hFFFF_C3A1);

        // R6 full 32-bit word, trailing-edge sampling
        en = 1'b0;
        configure(0, mk(0, 0, 0, 1, 0, 0, 0, 32));
        en = 1'b1;
        send(32'hDEAD_BEEF, 32'h8001_7FFE);

        // R6 minimum 2-bit word, upper bits of a busy slave word must read zero
        en = 1'b0;
        configure(0, mk(1, 0, 1, 0, 0, 0, 0, 2));
        en = 1'b1;
        send(32'hFFFF_FFFE, 32'hFFFF_FFFD);

        // R7 loopback, 12-bit, miso pattern must not appear
        en = 1'b0;
        configure(1, mk(0, 0, 1, 1, 1, 0, 0, 12));
        en = 1'b1;
        send(32'h0000_0ABC, 32'h0000_0555);

        // R8 transmitter off with idle level high, loopback returns idle pattern
        en = 1'b0;
        configure(0, mk(0, 1, 1, 1, 1, 1, 0, 8));
        en = 1'b1;
        send(32'h0000_0000, 32'h0000_0000);

        // R9 receiver off: no pulse, data held
        en = 1'b0;
        configure(0, mk(0, 0, 1, 1, 0, 0, 1, 8));
        en = 1'b1;
        held = rx_data;
        send(32'h0000_005A, 32'h0000_00C3);
        check(rx_data == held, "R9 rx_data held", rx_data, held);

        // R1 write while enabled is ignored: length and mode stay as before
        en = 1'b0;
        configure(0, mk(0, 0, 1, 1, 0, 0, 0, 8));
        en = 1'b1;
        configure(3, mk(1, 1, 0, 0, 0, 0, 0, 4));
        check(sclk == 1'b0, "R1 ignored write keeps polarity", 32'(sclk), 32'h0);
        send(32'h0000_00C7, 32'h0000_0019);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule